// File: doc/BRIEF.md
# Dual-Width Transfer FIFO Pair with DMA Pacing

This block holds the transmit and receive byte queues of a serial controller and presents both through one CPU data port. The serial shift engine pops transmit bytes one at a time from the head of the TX queue and appends received bytes one at a time to the RX queue. On the CPU side, a mode input selects the access width. In byte mode every data-port write or read moves a single byte. In word mode every access moves a 32-bit word whose lowest byte is the oldest byte.

A remaining-length counter is loaded before a word-mode transfer and counts down by the bytes each accepted write actually queues. The final word of a transfer can therefore carry one, two or three bytes. The block decodes occupancy flags for software polling. It also raises TX and RX DMA requests against two threshold inputs; the control register that drives them is expected to reset to 32.

Dropped writes and reads from an empty queue are reported through a sticky error flag. Each queue can be emptied by a flush strobe.

Top module: `xfer_fifo_pair`

## Requirements
- R1: After synchronous reset both queues are empty, the remaining length is 0, err_flag and cpu_rdata are 0, tx_room is 1, and rx_avail, rx_three_q, rx_full and tx_dreq are 0.
- R2: In byte mode (word_mode=0), an accepted write queues cpu_wdata[7:0] and ignores the upper bits. A read pops one byte, which appears in cpu_rdata[7:0] on the next cycle with bits 31:8 zero. Byte order is preserved, and each queue holds 64 bytes.
- R3: In word mode, an accepted write queues cpu_wdata[7:0] first, then [15:8], [23:16] and [31:24]. It queues four bytes, except when the remaining length is 1 to 3, when it queues only that many low bytes. A remaining length of 0 queues four bytes.
- R4: len_load sets the remaining length to len_value. Each accepted write lowers it by the number of bytes queued, stopping at 0. A load in the same cycle as a write takes priority.
- R5: In word mode, a read pops min(4, RX occupancy) bytes. The k-th oldest byte lands in cpu_rdata[8k+7:8k] on the next cycle, and lanes with no byte read as zero.
- R6: tx_room is 1 when TX occupancy is below 64 in byte mode, or at most 60 in word mode.
- R7: rx_avail is RX occupancy >= 1, rx_three_q is RX occupancy >= 48, and rx_full is RX occupancy == 64.
- R8: rx_dreq is 1 exactly when RX occupancy >= rx_thr.
- R9: tx_dreq is 1 exactly when TX occupancy <= tx_thr and the remaining length is non-zero.
- R10: flush_tx or flush_rx empties its queue in one cycle. A write, shifter pop or shifter push to that queue in the same cycle has no effect and raises no error.
- R11: A write while tx_room is 0 is dropped, and a read with RX empty returns zero. Both set err_flag, which holds until err_clr; a set in the same cycle wins over the clear.
- R12: sh_tx_valid shows that TX is non-empty, with the oldest byte on sh_tx_byte, and sh_tx_pop removes it. sh_rx_push appends sh_rx_byte unless RX is full, in which case the byte is discarded.
- R13: The CPU write is judged against TX occupancy before that cycle's shifter pop. The CPU read is judged against RX occupancy before that cycle's shifter push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 1: 32-bit packed access, 0: byte access |
| cpu_wr | input | 1 | Data-port write strobe |
| cpu_wdata | input | 32 | Data-port write data |
| cpu_rd | input | 1 | Data-port read strobe |
| cpu_rdata | output | 32 | Read data, registered, valid the cycle after cpu_rd |
| len_load | input | 1 | Load the remaining-length counter |
| len_value | input | 16 | Remaining length in bytes |
| tx_thr | input | 7 | TX DMA request threshold |
| rx_thr | input | 7 | RX DMA request threshold |
| flush_tx | input | 1 | Empty the TX queue |
| flush_rx | input | 1 | Empty the RX queue |
| err_clr | input | 1 | Clear the sticky error flag |
| sh_tx_pop | input | 1 | Shifter takes the head TX byte |
| sh_tx_byte | output | 8 | Head TX byte |
| sh_tx_valid | output | 1 | TX queue non-empty |
| sh_rx_push | input | 1 | Shifter delivers a received byte |
| sh_rx_byte | input | 8 | Received byte |
| tx_room | output | 1 | TX can accept one more data-port write |
| rx_avail | output | 1 | RX holds at least one byte |
| rx_three_q | output | 1 | RX holds at least 48 bytes |
| rx_full | output | 1 | RX holds 64 bytes |
| tx_dreq | output | 1 | TX DMA request |
| rx_dreq | output | 1 | RX DMA request |
| err_flag | output | 1 | Sticky overflow/underflow error |

## Verification
Each queue has two sides that can act in the same cycle: the CPU port and the shifter. The bench forces these collisions at the limits. A word or byte write meets a shifter pop while TX is full. A read meets a shifter push while RX is empty. A flush meets a write or push. A 64-byte RX meets a push while a word read drains it. A queue-based reference model, updated from the occupancy at the start of each cycle, judges every output on every clock. A long random phase with biased strobe rates repeats these coincidences with changing modes, lengths and thresholds.

// File: rtl/xfp_pkg.sv
package xfp_pkg;
  localparam int unsigned LANE_BITS = 8;

  typedef enum logic {
    ACC_BYTE = 1'b0,
    ACC_WORD = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/xfp_ring.sv
// Byte ring split into LANES banks so that up to LANES consecutive bytes
// can be written and read in one cycle, each bank touched at most once.
module xfp_ring #(
  parameter int DEPTH      = 64,
  parameter int LANES      = 4,
  parameter int PEEK_LANES = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   flush,
  input  logic [$clog2(LANES):0]                 push_n,
  input  logic [LANES*xfp_pkg::LANE_BITS-1:0]    push_data,
  input  logic [$clog2(LANES):0]                 pop_n,
  output logic [PEEK_LANES*xfp_pkg::LANE_BITS-1:0] peek_data,
  output logic [$clog2(DEPTH):0]                 level
);
  localparam int AW   = $clog2(DEPTH);
  localparam int LW   = $clog2(LANES);
  localparam int ROWS = DEPTH / LANES;
  localparam int RW   = $clog2(ROWS);
  localparam int CW   = AW + 1;
  localparam int NW   = LW + 1;
  localparam int B    = xfp_pkg::LANE_BITS;

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic [B-1:0]  bank_rd [LANES];

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [B-1:0]  mem [ROWS];
    logic [LW-1:0] wk;
    logic [RW-1:0] wrow, rrow;
    logic          we;

    // lane offset of this bank relative to the write pointer
    assign wk   = LW'(b) - wr_ptr[LW-1:0];
    assign we   = (NW'(wk) < push_n);
    assign wrow = wr_ptr[AW-1:LW] + ((LW'(b) < wr_ptr[LW-1:0]) ? RW'(1) : RW'(0));
    assign rrow = rd_ptr[AW-1:LW] + ((LW'(b) < rd_ptr[LW-1:0]) ? RW'(1) : RW'(0));

    always_ff @(posedge clk) begin
      if (we) mem[wrow] <= push_data[B*int'(wk) +: B];
    end

    assign bank_rd[b] = mem[rrow];
  end

  always_comb begin
    for (int k = 0; k < PEEK_LANES; k++) begin
      peek_data[B*k +: B] = bank_rd[rd_ptr[LW-1:0] + LW'(k)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop_n);
      cnt    <= cnt + CW'(push_n) - CW'(pop_n);
    end
  end

  assign level = cnt;
endmodule

// File: rtl/xfp_len_ctr.sv
// Remaining-length counter; decides how many bytes one write queues.
module xfp_len_ctr #(
  parameter int LEN_W = 16,
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [LEN_W-1:0]       load_val,
  input  logic                   take,
  input  logic                   word_mode,
  output logic [$clog2(LANES):0] chunk,
  output logic [LEN_W-1:0]       remaining
);
  localparam int NW = $clog2(LANES) + 1;

  always_comb begin
    if (!word_mode)                          chunk = NW'(1);
    else if (remaining == '0)                chunk = NW'(LANES);
    else if (remaining >= LEN_W'(LANES))     chunk = NW'(LANES);
    else                                     chunk = remaining[NW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                                   remaining <= '0;
    else if (load)                             remaining <= load_val;
    else if (take) begin
      if (LEN_W'(chunk) >= remaining)          remaining <= '0;
      else                                     remaining <= remaining - LEN_W'(chunk);
    end
  end
endmodule

// File: rtl/xfp_flags.sv
// Status and DMA request decode from registered occupancies.
module xfp_flags #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  parameter int LEN_W = 16
) (
  input  logic                    word_mode,
  input  logic [$clog2(DEPTH):0]  tx_lvl,
  input  logic [$clog2(DEPTH):0]  rx_lvl,
  input  logic [$clog2(DEPTH):0]  tx_thr,
  input  logic [$clog2(DEPTH):0]  rx_thr,
  input  logic [LEN_W-1:0]        remaining,
  output logic                    tx_room,
  output logic                    rx_avail,
  output logic                    rx_three_q,
  output logic                    rx_full,
  output logic                    tx_dreq,
  output logic                    rx_dreq
);
  localparam int CW      = $clog2(DEPTH) + 1;
  localparam int THREE_Q = (DEPTH * 3) / 4;

  assign tx_room    = word_mode ? (tx_lvl <= CW'(DEPTH - LANES)) : (tx_lvl < CW'(DEPTH));
  assign rx_avail   = (rx_lvl != '0);
  assign rx_three_q = (rx_lvl >= CW'(THREE_Q));
  assign rx_full    = (rx_lvl == CW'(DEPTH));
  assign rx_dreq    = (rx_lvl >= rx_thr);
  assign tx_dreq    = (tx_lvl <= tx_thr) && (remaining != '0);
endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  parameter int LEN_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    word_mode,
  input  logic                    cpu_wr,
  input  logic [LANES*8-1:0]      cpu_wdata,
  input  logic                    cpu_rd,
  output logic [LANES*8-1:0]      cpu_rdata,
  input  logic                    len_load,
  input  logic [LEN_W-1:0]        len_value,
  input  logic [$clog2(DEPTH):0]  tx_thr,
  input  logic [$clog2(DEPTH):0]  rx_thr,
  input  logic                    flush_tx,
  input  logic                    flush_rx,
  input  logic                    err_clr,
  input  logic                    sh_tx_pop,
  output logic [7:0]              sh_tx_byte,
  output logic                    sh_tx_valid,
  input  logic                    sh_rx_push,
  input  logic [7:0]              sh_rx_byte,
  output logic                    tx_room,
  output logic                    rx_avail,
  output logic                    rx_three_q,
  output logic                    rx_full,
  output logic                    tx_dreq,
  output logic                    rx_dreq,
  output logic                    err_flag
);
  import xfp_pkg::*;

  localparam int CW = $clog2(DEPTH) + 1;
  localparam int NW = $clog2(LANES) + 1;
  localparam int WB = LANES * LANE_BITS;

  acc_mode_e       mode;
  logic [CW-1:0]   tx_lvl, rx_lvl;
  logic [NW-1:0]   wr_chunk, tx_push_n, tx_pop_n, rx_push_n, rx_pop_n, rd_n;
  logic [LEN_W-1:0] remaining;
  logic [WB-1:0]   rx_peek, rd_next;
  logic            wr_ok, err_set;

  assign mode = word_mode ? ACC_WORD : ACC_BYTE;

  // ---------------- TX side ----------------
  assign wr_ok     = cpu_wr && tx_room && !flush_tx;
  assign tx_push_n = wr_ok ? wr_chunk : '0;
  assign tx_pop_n  = (sh_tx_pop && sh_tx_valid && !flush_tx) ? NW'(1) : '0;
  assign sh_tx_valid = (tx_lvl != '0);

  xfp_len_ctr #(.LEN_W(LEN_W), .LANES(LANES)) u_len (
    .clk       (clk),
    .rst       (rst),
    .load      (len_load),
    .load_val  (len_value),
    .take      (wr_ok),
    .word_mode (mode == ACC_WORD),
    .chunk     (wr_chunk),
    .remaining (remaining)
  );

  xfp_ring #(.DEPTH(DEPTH), .LANES(LANES), .PEEK_LANES(1)) u_tx_ring (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush_tx),
    .push_n    (tx_push_n),
    .push_data (cpu_wdata),
    .pop_n     (tx_pop_n),
    .peek_data (sh_tx_byte),
    .level     (tx_lvl)
  );

  // ---------------- RX side ----------------
  assign rx_push_n = (sh_rx_push && !rx_full && !flush_rx) ? NW'(1) : '0;

  always_comb begin
    if (rx_lvl == '0)              rd_n = '0;
    else if (mode == ACC_BYTE)     rd_n = NW'(1);
    else if (rx_lvl >= CW'(LANES)) rd_n = NW'(LANES);
    else                           rd_n = rx_lvl[NW-1:0];
  end

  assign rx_pop_n = (cpu_rd && !flush_rx) ? rd_n : '0;

  xfp_ring #(.DEPTH(DEPTH), .LANES(LANES), .PEEK_LANES(LANES)) u_rx_ring (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush_rx),
    .push_n    (rx_push_n),
    .push_data ({{(WB-LANE_BITS){1'b0}}, sh_rx_byte}),
    .pop_n     (rx_pop_n),
    .peek_data (rx_peek),
    .level     (rx_lvl)
  );

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      rd_next[LANE_BITS*k +: LANE_BITS] =
        (NW'(k) < rd_n) ? rx_peek[LANE_BITS*k +: LANE_BITS] : '0;
    end
  end

  // ---------------- flags ----------------
  xfp_flags #(.DEPTH(DEPTH), .LANES(LANES), .LEN_W(LEN_W)) u_flags (
    .word_mode  (mode == ACC_WORD),
    .tx_lvl     (tx_lvl),
    .rx_lvl     (rx_lvl),
    .tx_thr     (tx_thr),
    .rx_thr     (rx_thr),
    .remaining  (remaining),
    .tx_room    (tx_room),
    .rx_avail   (rx_avail),
    .rx_three_q (rx_three_q),
    .rx_full    (rx_full),
    .tx_dreq    (tx_dreq),
    .rx_dreq    (rx_dreq)
  );

  // ---------------- registered CPU outputs ----------------
  assign err_set = (cpu_wr && !tx_room && !flush_tx) || (cpu_rd && !rx_avail);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      err_flag  <= 1'b0;
    end else begin
      if (cpu_rd)       cpu_rdata <= rd_next;
      if (err_set)      err_flag  <= 1'b1;
      else if (err_clr) err_flag  <= 1'b0;
    end
  end
endmodule

// File: rtl/xfp_checker.sv
module xfp_checker #(
  parameter int DEPTH = 64,
  parameter int LANES = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   word_mode,
  input logic                   cpu_wr,
  input logic                   cpu_rd,
  input logic                   flush_tx,
  input logic                   flush_rx,
  input logic                   sh_tx_pop,
  input logic                   sh_rx_push,
  input logic                   tx_room,
  input logic                   rx_avail,
  input logic                   rx_three_q,
  input logic                   rx_full,
  input logic                   sh_tx_valid,
  input logic                   err_flag,
  input logic [LANES*8-1:0]     cpu_rdata,
  input logic [$clog2(DEPTH):0] tx_lvl,
  input logic [$clog2(DEPTH):0] rx_lvl
);
  localparam int CW = $clog2(DEPTH) + 1;

  AST_FULL_NESTS: assert property (@(posedge clk) disable iff (rst)
    rx_full |-> (rx_three_q && rx_avail)); // R7

  AST_RX_FULL_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (rx_full && sh_rx_push && !cpu_rd && !flush_rx) |=> (rx_full && $stable(rx_lvl))); // R12

  AST_EMPTY_READ_ERR: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !rx_avail) |=> (err_flag && cpu_rdata == '0)); // R11

  AST_FLUSH_TX_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush_tx |=> !sh_tx_valid); // R10

  AST_BYTE_PUSH_ONE: assert property (@(posedge clk) disable iff (rst)
    (!word_mode && cpu_wr && tx_room && !flush_tx && !sh_tx_pop)
      |=> (tx_lvl == $past(tx_lvl) + CW'(1))); // R2

  AST_WORD_POP_FOUR: assert property (@(posedge clk) disable iff (rst)
    (word_mode && cpu_rd && rx_lvl >= CW'(LANES) && !sh_rx_push && !flush_rx)
      |=> (rx_lvl == $past(rx_lvl) - CW'(LANES))); // R5
endmodule

bind xfer_fifo_pair xfp_checker #(.DEPTH(DEPTH), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .word_mode   (word_mode),
  .cpu_wr      (cpu_wr),
  .cpu_rd      (cpu_rd),
  .flush_tx    (flush_tx),
  .flush_rx    (flush_rx),
  .sh_tx_pop   (sh_tx_pop),
  .sh_rx_push  (sh_rx_push),
  .tx_room     (tx_room),
  .rx_avail    (rx_avail),
  .rx_three_q  (rx_three_q),
  .rx_full     (rx_full),
  .sh_tx_valid (sh_tx_valid),
  .err_flag    (err_flag),
  .cpu_rdata   (cpu_rdata),
  .tx_lvl      (tx_lvl),
  .rx_lvl      (rx_lvl)
);

// File: tb/xfer_fifo_pair_test.sv
`timescale 1ns/1ps
module xfer_fifo_pair_test;
  localparam int DEPTH = 64;
  localparam int LANES = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_mode = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic [31:0] cpu_rdata;
  logic        len_load = 1'b0;
  logic [15:0] len_value = '0;
  logic [6:0]  tx_thr = 7'd32;
  logic [6:0]  rx_thr = 7'd32;
  logic        flush_tx = 1'b0, flush_rx = 1'b0, err_clr = 1'b0;
  logic        sh_tx_pop = 1'b0;
  logic [7:0]  sh_tx_byte;
  logic        sh_tx_valid;
  logic        sh_rx_push = 1'b0;
  logic [7:0]  sh_rx_byte = '0;
  logic        tx_room, rx_avail, rx_three_q, rx_full, tx_dreq, rx_dreq, err_flag;

  always #2.5 clk = ~clk;

  xfer_fifo_pair uut (
    .clk(clk), .rst(rst), .word_mode(word_mode), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .len_load(len_load), .len_value(len_value),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .flush_tx(flush_tx), .flush_rx(flush_rx),
    .err_clr(err_clr), .sh_tx_pop(sh_tx_pop), .sh_tx_byte(sh_tx_byte),
    .sh_tx_valid(sh_tx_valid), .sh_rx_push(sh_rx_push), .sh_rx_byte(sh_rx_byte),
    .tx_room(tx_room), .rx_avail(rx_avail), .rx_three_q(rx_three_q), .rx_full(rx_full),
    .tx_dreq(tx_dreq), .rx_dreq(rx_dreq), .err_flag(err_flag)
  );

  // reference model state
  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];
  int          rem = 0;
  bit          merr = 1'b0;
  logic [31:0] mrdata = '0;

  int    checks = 0;
  int    errors = 0;
  string ctx = "reset";

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s]: actual %h expected %h", what, ctx, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic compare_all();
    int txc = txq.size();
    int rxc = rxq.size();
    chk("R12 sh_tx_valid", 32'(sh_tx_valid), 32'(txc > 0));
    if (txc > 0) chk("R12 sh_tx_byte", 32'(sh_tx_byte), 32'(txq[0]));
    chk("R6 tx_room", 32'(tx_room), 32'(word_mode ? (txc <= DEPTH - LANES) : (txc < DEPTH)));
    chk("R7 rx_avail", 32'(rx_avail), 32'(rxc >= 1));
    chk("R7 rx_three_q", 32'(rx_three_q), 32'(rxc >= 48));
    chk("R7 rx_full", 32'(rx_full), 32'(rxc == DEPTH));
    chk("R8 rx_dreq", 32'(rx_dreq), 32'(rxc >= int'(rx_thr)));
    chk("R9 tx_dreq", 32'(tx_dreq), 32'(txc <= int'(tx_thr) && rem != 0));
    chk("R11 err_flag", 32'(err_flag), 32'(merr));
    chk(word_mode ? "R5 cpu_rdata" : "R2 cpu_rdata", cpu_rdata, mrdata);
  endtask

  // one clock: model the cycle from pre-edge state, then compare
  task automatic step();
    int txc = txq.size();
    int rxc = rxq.size();
    bit room = word_mode ? (txc <= DEPTH - LANES) : (txc < DEPTH);
    int wb = !word_mode ? 1 : ((rem == 0 || rem >= LANES) ? LANES : rem);
    bit wacc = cpu_wr && room && !flush_tx;
    bit eset = (cpu_wr && !room && !flush_tx) || (cpu_rd && rxc == 0);
    int rn = (rxc == 0) ? 0 : (!word_mode ? 1 : ((rxc >= LANES) ? LANES : rxc));
    logic [31:0] nrd = mrdata;
    if (cpu_rd) begin
      nrd = '0;
      for (int k = 0; k < rn; k++) nrd[8*k +: 8] = rxq[k];
    end
    @(posedge clk);
    if (rst) begin
      txq.delete(); rxq.delete(); rem = 0; merr = 1'b0; mrdata = '0;
    end else begin
      if (flush_tx) txq.delete();
      else begin
        if (sh_tx_pop && txc > 0) void'(txq.pop_front());
        if (wacc) for (int k = 0; k < wb; k++) txq.push_back(cpu_wdata[8*k +: 8]);
      end
      if (flush_rx) rxq.delete();
      else begin
        if (cpu_rd) for (int k = 0; k < rn; k++) void'(rxq.pop_front());
        if (sh_rx_push && rxc < DEPTH) rxq.push_back(sh_rx_byte);
      end
      if (len_load) rem = int'(len_value);
      else if (wacc) rem = (wb >= rem) ? 0 : rem - wb;
      if (eset) merr = 1'b1;
      else if (err_clr) merr = 1'b0;
      mrdata = nrd;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    cpu_wr = 0; cpu_rd = 0; len_load = 0; flush_tx = 0; flush_rx = 0;
    err_clr = 0; sh_tx_pop = 0; sh_rx_push = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog [R1]: actual hung expected finished");
    finish_sim();
  end

  initial begin
    // ---- R1 reset ----
    step(); step();
    rst = 0;
    step();
    chk("R1 tx_room", 32'(tx_room), 32'd1);
    chk("R1 rx_avail", 32'(rx_avail), 32'd0);
    chk("R1 sh_tx_valid", 32'(sh_tx_valid), 32'd0);
    chk("R1 tx_dreq", 32'(tx_dreq), 32'd0);
    chk("R1 rx_full", 32'(rx_full), 32'd0);
    chk("R1 err_flag", 32'(err_flag), 32'd0);
    chk("R1 cpu_rdata", cpu_rdata, 32'd0);

    // ---- R2 byte mode write, shifter loopback, byte reads ----
    ctx = "R2 byte order";
    for (int i = 0; i < 5; i++) begin
      cpu_wr = 1; cpu_wdata = 32'hABCD_0010 + 32'(i); step();
    end
    idle_inputs();
    for (int i = 0; i < 5; i++) begin
      sh_tx_pop = 1; sh_rx_push = 1; sh_rx_byte = 8'h40 + 8'(i); step();
    end
    idle_inputs();
    for (int i = 0; i < 6; i++) begin cpu_rd = 1; step(); end
    idle_inputs(); err_clr = 1; step(); idle_inputs();
    chk("R11 err cleared", 32'(err_flag), 32'd0);

    // ---- R13 TX full: write and pop in same cycle ----
    ctx = "R13 tx full collision";
    for (int i = 0; i < DEPTH; i++) begin
      cpu_wr = 1; cpu_wdata = 32'(i * 3); step();
    end
    cpu_wr = 1; sh_tx_pop = 1; cpu_wdata = 32'hEE; step();
    idle_inputs();
    chk("R13 dropped write flagged", 32'(err_flag), 32'd1);
    word_mode = 1; step();     // 63 bytes: no word room
    cpu_wr = 1; cpu_wdata = 32'h11223344; step(); idle_inputs();
    // ---- R10 flush with concurrent write ----
    ctx = "R10 flush";
    err_clr = 1; flush_tx = 1; cpu_wr = 1; step(); idle_inputs();
    chk("R10 tx empty after flush", 32'(sh_tx_valid), 32'd0);
    chk("R10 no error from flushed write", 32'(err_flag), 32'd0);

    // ---- R3/R4 word mode with partial final word ----
    ctx = "R3 R4 word length";
    len_load = 1; len_value = 16'd10; step(); idle_inputs();
    chk("R9 dreq with length", 32'(tx_dreq), 32'd1);
    for (int i = 0; i < 4; i++) begin
      cpu_wr = 1; cpu_wdata = 32'hA0B0C0D0 + 32'(i * 32'h01010101); step();
    end
    idle_inputs();
    chk("R4 length spent", 32'(tx_dreq), 32'd0);
    for (int i = 0; i < 16; i++) begin sh_tx_pop = 1; step(); end
    idle_inputs();

    // ---- R5 word reads, R7/R8 levels, R12 discard when full ----
    ctx = "R5 R7 rx word";
    rx_thr = 7'd40;
    for (int i = 0; i < 7; i++) begin sh_rx_push = 1; sh_rx_byte = 8'h70 + 8'(i); step(); end
    idle_inputs();
    cpu_rd = 1; step(); step(); step(); idle_inputs();
    err_clr = 1; step(); idle_inputs();
    for (int i = 0; i < DEPTH + 3; i++) begin sh_rx_push = 1; sh_rx_byte = 8'(i ^ 8'h5A); step(); end
    ctx = "R13 rx full push with word read";
    cpu_rd = 1; step(); idle_inputs();
    for (int i = 0; i < 20; i++) begin cpu_rd = 1; step(); end
    idle_inputs();
    // ---- R13 RX empty: push and read same cycle ----
    ctx = "R13 rx empty collision";
    cpu_rd = 1; sh_rx_push = 1; sh_rx_byte = 8'h99; step(); idle_inputs();
    chk("R13 empty read zero", cpu_rdata, 32'd0);
    ctx = "R10 flush rx";
    flush_rx = 1; sh_rx_push = 1; step(); idle_inputs();
    chk("R10 rx empty after flush", 32'(rx_avail), 32'd0);

    // ---- random phases ----
    for (int ph = 0; ph < 4; ph++) begin
      ctx = $sformatf("random phase %0d R2 R3 R4 R5 R12 R13", ph);
      for (int c = 0; c < 900; c++) begin
        cpu_wr     = ($urandom_range(0, 99) < ((ph % 2) ? 60 : 25));
        cpu_wdata  = $urandom;
        cpu_rd     = ($urandom_range(0, 99) < ((ph >= 2) ? 20 : 45));
        sh_tx_pop  = ($urandom_range(0, 99) < ((ph % 2) ? 20 : 55));
        sh_rx_push = ($urandom_range(0, 99) < ((ph >= 2) ? 70 : 30));
        sh_rx_byte = 8'($urandom);
        len_load   = ($urandom_range(0, 99) < 3);
        len_value  = 16'($urandom_range(0, 150));
        flush_tx   = ($urandom_range(0, 199) == 0);
        flush_rx   = ($urandom_range(0, 199) == 0);
        err_clr    = ($urandom_range(0, 15) == 0);
        if (c % 100 == 0) begin
          word_mode = $urandom_range(0, 1);
          tx_thr = 7'($urandom_range(0, 64));
          rx_thr = 7'($urandom_range(1, 64));
        end
        step();
      end
    end
    idle_inputs();
    step();
    finish_sim();
  end
endmodule